// File: doc/BRIEF.md
# In-band loop code generator

This block produces a serial bit stream for signalling loop-up and loop-down commands on a T1-style line. The stream is a user-defined pattern of 5 to 8 bits that repeats for as long as the loop-code transmit enable is set. The pattern sits left-justified in an 8-bit code input and goes out most significant bit first. When the enable is clear, the block passes the framer's normal data bit straight to its output.

A free-running frame position counter marks one bit in every 193 as the framing-bit position. A frame sync strobe from the framer realigns this counter. When framing-bit insertion is enabled, the framing bit from the framer replaces the pattern at that position. The pattern index does not advance there, so the pattern carries on where it paused. A new code or length value is taken in only when the current pattern finishes, and the new pattern then starts at its first bit.

Top module: `loop_code_gen`

## Requirements
- R1: The pattern period L is set by `len_sel`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Not counting held framing positions, the stream repeats every L bits.
- R2: Pattern bit k (k = 0 .. L-1) is `code_def[7-k]`, so the MSB goes out first. For example, code 0x80 with `len_sel` 00 gives 1000010000... .
- R3: While `loop_en` is 0, `ser_out` equals `data_in` and the pattern index goes back to 0. Each clock also loads the current code and length, so setting `loop_en` starts the pattern from its MSB.
- R4: While `loop_en` and `fbit_ins_en` are both 1, `ser_out` equals `fbit_in` at the framing-bit position.
- R5: At a framing-bit position with insertion enabled, the pattern index holds its value. The next pattern bit is the one that was due at that position.
- R6: The framing-bit position comes once every 193 bits, at frame count 0. A high `frame_sync` makes the current bit the framing position, and the count restarts from there.
- R7: A change on `code_def` or `len_sel` while the pattern runs takes effect only after the last bit of the current pattern. The new pattern then starts at its MSB.
- R8: During and right after reset, `ser_out` equals `data_in`, the frame count is 0 (so the first bit after reset is a framing position), and the pattern index is 0.
- R9: With `fbit_ins_en` at 0, the framing position carries a pattern bit and the index advances normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_def | input | 8 | Left-justified pattern |
| len_sel | input | 2 | Pattern length select (5 + value) |
| loop_en | input | 1 | Send the pattern instead of data |
| fbit_ins_en | input | 1 | Let the framing bit through at its position |
| frame_sync | input | 1 | Marks the current bit as the framing position |
| fbit_in | input | 1 | Framing bit value from the framer |
| data_in | input | 1 | Normal data bit |
| ser_out | output | 1 | Serial output bit |

## Verification
The bench first checks the 0x80, five-bit stream bit for bit. It then changes code and length in the middle of a pattern. A design that takes the change at once would cut the pattern short or jump to a bit other than the MSB. The bench runs insertion across many frame boundaries: a design that advanced the index on the framing position would drop one pattern bit per frame. It also pulses the frame sync at odd places and toggles insertion off. These cases would expose a counter that ignores realignment or that holds the index when insertion is disabled.

// File: rtl/loop_code_gen.sv
module loop_code_gen #(
  parameter int CODE_W     = 8,
  parameter int SEL_W      = 2,
  parameter int MIN_LEN    = 5,
  parameter int FRAME_BITS = 193
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_def,
  input  logic [SEL_W-1:0]  len_sel,
  input  logic              loop_en,
  input  logic              fbit_ins_en,
  input  logic              frame_sync,
  input  logic              fbit_in,
  input  logic              data_in,
  output logic              ser_out
);
  localparam int IDX_W = $clog2(CODE_W);
  localparam int CNT_W = $clog2(FRAME_BITS);

  logic [CODE_W-1:0] code_q;
  logic [SEL_W-1:0]  len_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W:0]    last_idx;
  logic [IDX_W-1:0]  bit_sel;
  logic              f_pos, hold, wrap, adv;

  assign last_idx = (IDX_W+1)'(MIN_LEN - 1) + (IDX_W+1)'(len_q);
  assign f_pos    = frame_sync || (cnt_q == '0);
  assign hold     = fbit_ins_en && f_pos;
  assign wrap     = ({1'b0, idx_q} == last_idx);
  assign adv      = loop_en && !hold;
  assign bit_sel  = IDX_W'(CODE_W - 1) - idx_q;
  assign ser_out  = !loop_en ? data_in : (hold ? fbit_in : code_q[bit_sel]);

  always_ff @(posedge clk) begin
    if (!rst_n)                              cnt_q <= '0;
    else if (f_pos)                          cnt_q <= CNT_W'(1);
    else if (cnt_q == CNT_W'(FRAME_BITS-1))  cnt_q <= '0;
    else                                     cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
    end else if (!loop_en || (adv && wrap)) begin
      code_q <= code_def;
      len_q  <= len_sel;
      idx_q  <= '0;
    end else if (adv) begin
      idx_q  <= idx_q + IDX_W'(1);
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) {1'b0, idx_q} <= last_idx); // R1
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !loop_en |=> (idx_q == '0) && (code_q == $past(code_def))); // R3
  AST_F_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (loop_en && hold) |=> $stable(idx_q)); // R5
  AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) (cnt_q == CNT_W'(FRAME_BITS-1) && !frame_sync) |=> (cnt_q == '0)); // R6
  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (loop_en && !(adv && wrap)) |=> $stable(code_q) && $stable(len_q)); // R7
endmodule

// File: tb/loop_code_gen_test.sv
module loop_code_gen_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [7:0] code_def = 8'h00;
  logic [1:0] len_sel = 2'b00;
  logic       loop_en = 1'b0, fbit_ins_en = 1'b0, frame_sync = 1'b0;
  logic       fbit_in = 1'b0, data_in = 1'b0;
  logic       ser_out;

  loop_code_gen uut (
    .clk(clk), .rst_n(rst_n), .code_def(code_def), .len_sel(len_sel),
    .loop_en(loop_en), .fbit_ins_en(fbit_ins_en), .frame_sync(frame_sync),
    .fbit_in(fbit_in), .data_in(data_in), .ser_out(ser_out)
  );

  int total = 0, bad = 0;
  int m_cnt = 0, m_idx = 0;
  logic [7:0] m_code = 8'h00;
  logic [1:0] m_len = 2'b00;
  bit prev_held = 0, prev_sync = 0;

  task automatic check(input logic got, input logic exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    bit fp, hd;
    logic e;
    string req;
    @(negedge clk);
    fp = frame_sync || (m_cnt == 0);
    hd = fbit_ins_en && fp;
    prev_held = loop_en && hd;
    prev_sync = frame_sync;
    if (!rst_n) begin
      m_cnt = 0; m_idx = 0; m_code = 8'h00; m_len = 2'b00;
    end else begin
      m_cnt = fp ? 1 : ((m_cnt == 192) ? 0 : m_cnt + 1);
      if (!loop_en) begin
        m_idx = 0; m_code = code_def; m_len = len_sel;
      end else if (!hd) begin
        if (m_idx == 4 + int'(m_len)) begin
          m_idx = 0; m_code = code_def; m_len = len_sel;
        end else m_idx++;
      end
    end
    fp = frame_sync || (m_cnt == 0);
    hd = fbit_ins_en && fp;
    e = !loop_en ? data_in : (hd ? fbit_in : m_code[7 - m_idx]);
    if (!rst_n) req = "R8";
    else if (!loop_en) req = "R3";
    else if (hd) req = "R4";
    else if (prev_held) req = "R5";
    else if (fp) req = "R9";
    else if (code_def != m_code || len_sel != m_len) req = "R7";
    else if (prev_sync) req = "R6";
    else req = "R2";
    check(ser_out, e, req);
  endtask

  logic [9:0] got_bits;
  bit done = 0;

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    data_in = 1'b1;
    repeat (3) tick();
    #1 check(ser_out, 1'b1, "R8 passthrough in reset");
    @(negedge clk);
    rst_n = 1'b1;
    code_def = 8'h80; len_sel = 2'b00;
    tick();
    loop_en = 1'b1;
    #1 got_bits[9] = ser_out;
    for (int k = 8; k >= 0; k--) begin
      tick();
      got_bits[k] = ser_out;
    end
    check(got_bits == 10'b1000010000, 1'b1, "R1 R2 0x80 len5 stream");
    // R7: mid-pattern change, then R5/R4 with insertion over frames
    code_def = 8'hFF; len_sel = 2'b11;
    repeat (12) tick();
    fbit_ins_en = 1'b1;
    code_def = 8'hA6; len_sel = 2'b10;
    repeat (600) begin
      fbit_in = 1'($urandom);
      tick();
    end
    // R6: sync pulse off-frame
    frame_sync = 1'b1; tick(); frame_sync = 1'b0;
    repeat (200) tick();
    // R9: insertion off across a frame
    fbit_ins_en = 1'b0;
    repeat (250) tick();
    for (int n = 0; n < 4000; n++) begin
      data_in = 1'($urandom);
      fbit_in = 1'($urandom);
      frame_sync = ($urandom % 300) == 0;
      if (($urandom % 60) == 0) loop_en = ~loop_en;
      if (($urandom % 40) == 0) begin
        code_def = 8'($urandom);
        len_sel = 2'($urandom);
      end
      if (($urandom % 150) == 0) fbit_ins_en = ~fbit_ins_en;
      tick();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule